// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single-cycle write requests from synchronous logic into correctly timed write cycles on an external asynchronous static RAM. The RAM is 16 bits wide, holds 128K words and has two independently enabled byte lanes. A write request carries an address, a data word and a two-bit lane mask. The block answers each request with a one-clock completion pulse. On the memory side it drives the active-low chip select, the write strobe and the two lane enables. It also drives the address bus, the outgoing data word and an output enable for the data pads.

The RAM stores data only while chip select, the write strobe and at least one lane enable are all low together. Raising any one of them ends the write, and the data and address margins are measured from that edge. The sequencer always ends a write by raising the write strobe. It first presents the address, chip select, lane enables and data one clock before the strobe falls. It keeps all of them unchanged for one clock after the strobe rises. Every wait count is worked out at elaboration from the RAM's timing minimums and a clock-period parameter given in nanoseconds, so the same code serves any speed grade and any clock.

Top module: `asyncSramWriter`

## Requirements
- R1: While reset is held, and right after it, memCeN, memWeN and both memBeN bits are 1, memDqOe is 0 and reqDone is 0.
- R2: A request sampled while idle with a nonzero mask leads, after that clock edge, to memCeN=0, memWeN=1, memDqOe=1, memAddr and memDqOut equal to the request, and memBeN equal to the inverted mask (bit 0 is the lower byte, bit 1 the upper byte). This state lasts exactly one clock.
- R3: memWeN then stays low for exactly PULSE clocks. PULSE is the larger of ceil(tPwe/CLK_NS) and ceil(max(tAw, tSce, tPwb, tSd)/CLK_NS) - 1.
- R4: memAddr and memDqOut do not change while a write is active. memCeN, memBeN, memAddr and memDqOut are all unchanged in the clock after memWeN rises.
- R5: memDqOe is 1 from the clock the strobes start until one clock after memWeN rises, and 0 at every other time. memCeN and memBeN return high at that same edge.
- R6: reqDone is a single-clock pulse. It appears TOTAL clocks after the accepting edge, where TOTAL = max(PULSE + 2, ceil(tWc/CLK_NS)).
- R7: As seen by the memory, the strobe overlap is at least tPwe long. At the moment the write ends, the address has been steady for at least tAw, the data for at least tSd, chip select low for at least tSce and the lane enables valid for at least tPwb. Two chip-select falls are at least tWc apart.
- R8: A request with mask 00 produces reqDone on the next clock and moves no memory-side signal.
- R9: A request raised while a write is in progress is ignored. It produces no write and no reqDone.
- R10: Only the lanes selected by the mask are written. The other lane of the same word keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request, sampled while idle |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | DATA_W | Write data of the request |
| reqMask | input | LANES | Lane select, bit 0 lower byte, bit 1 upper byte |
| reqDone | output | 1 | One-clock completion pulse |
| memAddr | output | ADDR_W | RAM address bus |
| memDqOut | output | DATA_W | Data driven toward the RAM pads |
| memDqOe | output | 1 | Pad output enable for memDqOut |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memBeN | output | LANES | Lane enables, active low, bit 0 lower byte |

## Verification
The bench builds the block with CLK_NS = 4 and the slowest grade's limits: tWc 100, tSce/tAw/tPwb/tPwe 80 and tSd 40. This gives a 20-clock strobe and a 25-clock cycle, so three recovery clocks are needed after the hold clock. That exercises the recovery path, which the default 10 ns, fastest-grade build leaves empty. The strobe width lands exactly on its 80 ns minimum, so the behavioural memory's timing checks work at the boundary. The bench also places a stray request inside both the strobe and the recovery window.

// File: rtl/sramWrPkg.sv
package sramWrPkg;

  // Strobe bundle from control to datapath, active high internally.
  typedef struct packed {
    logic chipSel;   // select the RAM (setup, strobe and hold clocks)
    logic writeStb;  // write strobe low on the pins
    logic driveBus;  // pads drive the data word
    logic load;      // capture the request into the datapath
  } wrStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramWrCtrl.sv
module sramWrCtrl
  import sramWrPkg::*;
#(
  parameter int LANES     = 2,
  parameter int PULSE_CYC = 5,
  parameter int RECOV_CYC = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LANES-1:0] reqMask,
  output wrStrobe_t        nextStb,
  output logic             reqDone
);

  localparam int CNT_MAX = maxOf(PULSE_CYC, RECOV_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'((RECOV_CYC > 0) ? RECOV_CYC - 1 : 0);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_RECOV
  } wrState_e;

  wrState_e         state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             doneNext;
  logic             accept;

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    doneNext    = 1'b0;
    accept      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqMask != '0) begin
            stateNext = ST_SETUP;
            accept    = 1'b1;
          end else begin
            doneNext  = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        stateNext   = ST_STROBE;
        waitCntNext = PULSE_LOAD;
      end
      ST_STROBE: begin
        if (waitCnt == '0) stateNext = ST_HOLD;
        else               waitCntNext = waitCnt - 1'b1;
      end
      ST_HOLD: begin
        if (RECOV_CYC == 0) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end else begin
          stateNext   = ST_RECOV;
          waitCntNext = RECOV_LOAD;
        end
      end
      ST_RECOV: begin
        if (waitCnt == '0) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Strobes follow the next state so the datapath can register the pins.
  always_comb begin
    nextStb.chipSel  = (stateNext == ST_SETUP) || (stateNext == ST_STROBE) ||
                       (stateNext == ST_HOLD);
    nextStb.writeStb = (stateNext == ST_STROBE);
    nextStb.driveBus = nextStb.chipSel;
    nextStb.load     = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      reqDone <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
      reqDone <= doneNext;
    end
  end

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqMask == '0) |=> (reqDone && state == ST_IDLE));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> (state == ST_IDLE));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && reqValid) |=> (state == ST_STROBE || state == ST_HOLD));

endmodule

// File: rtl/sramWrPath.sv
module sramWrPath
  import sramWrPkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int PULSE_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         nextStb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqMask,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN
);

  localparam int LANE_W = DATA_W / LANES;
  localparam int RUN_W  = $clog2(PULSE_CYC + 2);

  // Shared strobes, all registered straight to the pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memCeN  <= 1'b1;
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
    end else begin
      if (nextStb.load) memAddr <= reqAddr;
      memCeN  <= !nextStb.chipSel;
      memWeN  <= !nextStb.writeStb;
      memDqOe <= nextStb.driveBus;
    end
  end

  // One slice per byte lane: lane enable and its data byte.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memBeN[g]                        <= 1'b1;
        memDqOut[g*LANE_W +: LANE_W]     <= '0;
      end else if (nextStb.load) begin
        memBeN[g]                        <= !reqMask[g];
        memDqOut[g*LANE_W +: LANE_W]     <= reqData[g*LANE_W +: LANE_W];
      end else if (!nextStb.chipSel) begin
        memBeN[g]                        <= 1'b1;
      end
    end
  end

  // Checker: length of the current low run of the write strobe.
  logic [RUN_W-1:0] weLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        weLowRun <= '0;
    else if (!memWeN) weLowRun <= weLowRun + 1'b1;
    else              weLowRun <= '0;
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowRun == RUN_W'(PULSE_CYC)));

  // R2
  strobe_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(!memCeN) && $stable(memAddr) && $stable(memDqOut)));

  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && memBeN != '1 && memDqOe &&
                       $stable(memAddr) && $stable(memDqOut) && $stable(memBeN)));

  // R5
  bus_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memCeN);

  // R5
  strobe_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe && !memCeN));

endmodule

// File: rtl/asyncSramWriter.sv
module asyncSramWriter
  import sramWrPkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int CLK_NS = 10,
  parameter int T_WC   = 55,
  parameter int T_SCE  = 50,
  parameter int T_AW   = 50,
  parameter int T_PWB  = 45,
  parameter int T_PWE  = 45,
  parameter int T_SD   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqMask,
  output logic              reqDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN
);

  // Margins counted from the accepting edge need one clock less than
  // the strobe itself, since the setup clock comes before the strobe.
  localparam int LEAD_NS   = maxOf(maxOf(T_AW, T_SCE), maxOf(T_PWB, T_SD));
  localparam int PULSE_CYC = maxOf(maxOf(ceilDiv(T_PWE, CLK_NS), ceilDiv(LEAD_NS, CLK_NS) - 1), 1);
  localparam int TOTAL_CYC = maxOf(PULSE_CYC + 2, ceilDiv(T_WC, CLK_NS));
  localparam int RECOV_CYC = TOTAL_CYC - PULSE_CYC - 2;

  wrStrobe_t nextStb;

  sramWrCtrl #(
    .LANES     (LANES),
    .PULSE_CYC (PULSE_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMask  (reqMask),
    .nextStb  (nextStb),
    .reqDone  (reqDone)
  );

  sramWrPath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .PULSE_CYC (PULSE_CYC)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .nextStb  (nextStb),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqMask  (reqMask),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memBeN   (memBeN)
  );

endmodule

// File: tb/test_asyncSramWriter.sv
`timescale 1ns/1ps
module test_asyncSramWriter;

  localparam int CLK  = 4;
  localparam int AW   = 17;
  localparam int DW   = 16;
  localparam int LN   = 2;
  localparam int TWC  = 100;
  localparam int TSCE = 80;
  localparam int TAW  = 80;
  localparam int TPWB = 80;
  localparam int TPWE = 80;
  localparam int TSD  = 40;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_PULSE = imax(cdiv(TPWE, CLK),
                                  cdiv(imax(imax(TAW, TSCE), imax(TPWB, TSD)), CLK) - 1);
  localparam int EXP_TOTAL = imax(EXP_PULSE + 2, cdiv(TWC, CLK));

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [LN-1:0] reqMask = '0;
  logic          reqDone;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDqOut;
  logic          memDqOe;
  logic          memCeN;
  logic          memWeN;
  logic [LN-1:0] memBeN;

  asyncSramWriter #(
    .ADDR_W(AW), .DATA_W(DW), .LANES(LN), .CLK_NS(CLK),
    .T_WC(TWC), .T_SCE(TSCE), .T_AW(TAW), .T_PWB(TPWB), .T_PWE(TPWE), .T_SD(TSD)
  ) i_asyncSramWriter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .reqMask(reqMask), .reqDone(reqDone),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memCeN(memCeN), .memWeN(memWeN), .memBeN(memBeN)
  );

  always #(CLK/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [LN-1:0] m;
  } wrItem_t;

  wrItem_t       wrQ[$];
  int            doneQ[$];
  logic [DW-1:0] expMem[int];
  logic [DW-1:0] modMem[int];

  // Behavioural RAM: write overlap and its timing checks.
  logic wrAct;
  assign wrAct = !memCeN && !memWeN && (memBeN != 2'b11);
  realtime tAddr = 0, tData = 0, tCeFall = 0, tBeSet = 0, tWeFall = 0;
  realtime tLastCe = -1000.0;

  always @(memAddr) begin
    if (rstN && wrAct) chk(1'b0, "R4", "address moved during write", memAddr, 0);
    tAddr = $realtime;
  end
  always @(memDqOut) begin
    if (rstN && wrAct) chk(1'b0, "R4", "data moved during write", memDqOut, 0);
    tData = $realtime;
  end
  always @(memBeN) tBeSet = $realtime;
  always @(negedge memCeN) begin
    if (rstN) begin
      chk(($realtime - tLastCe) >= TWC, "R7", "cycle time ns",
          longint'($rtoi($realtime - tLastCe)), TWC);
      tLastCe = $realtime;
      tCeFall = $realtime;
    end
  end
  always @(posedge wrAct) begin
    if (rstN) begin
      tWeFall = $realtime;
      chk(memDqOe == 1'b1, "R5", "bus driven at write start", memDqOe, 1);
    end
  end
  always @(negedge wrAct) begin
    if (rstN) begin
      realtime t;
      logic [DW-1:0] w;
      t = $realtime;
      chk((t - tWeFall) >= TPWE, "R7", "strobe width ns", longint'($rtoi(t - tWeFall)), TPWE);
      chk((t - tAddr) >= TAW, "R7", "address setup ns", longint'($rtoi(t - tAddr)), TAW);
      chk((t - tData) >= TSD, "R7", "data setup ns", longint'($rtoi(t - tData)), TSD);
      chk((t - tCeFall) >= TSCE, "R7", "select to end ns", longint'($rtoi(t - tCeFall)), TSCE);
      chk((t - tBeSet) >= TPWB, "R7", "lane valid to end ns", longint'($rtoi(t - tBeSet)), TPWB);
      w = modMem.exists(int'(memAddr)) ? modMem[int'(memAddr)] : 16'h0000;
      if (!memBeN[0]) w[7:0]  = memDqOut[7:0];
      if (!memBeN[1]) w[15:8] = memDqOut[15:8];
      modMem[int'(memAddr)] = w;
      // Scoreboard: compare the finished write with the oldest expected one.
      if (wrQ.size() == 0) begin
        chk(1'b0, "R9", "write with no request", memAddr, 0);
      end else begin
        wrItem_t e;
        e = wrQ.pop_front();
        chk(memAddr == e.a, "R10", "write address", memAddr, e.a);
        chk(~memBeN == e.m, "R10", "lane enables", ~memBeN, e.m);
        if (e.m[0]) chk(memDqOut[7:0] == e.d[7:0], "R10", "lower byte", memDqOut[7:0], e.d[7:0]);
        if (e.m[1]) chk(memDqOut[15:8] == e.d[15:8], "R10", "upper byte", memDqOut[15:8], e.d[15:8]);
      end
    end
  end

  // Pin monitor: done timing, strobe length, hold and release clocks.
  int   lowRun  = 0;
  int   holdAge = 0;
  logic prevWeN = 1'b1;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevData = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (reqDone) begin
        if (doneQ.size() == 0) chk(1'b0, "R9", "unexpected done", cyc, 0);
        else begin
          int e;
          e = doneQ.pop_front();
          chk(cyc == e, "R6", "done cycle", cyc, e);
        end
      end
      if (!memWeN) lowRun++;
      if (!prevWeN && memWeN) begin
        chk(lowRun == EXP_PULSE, "R3", "strobe clocks", lowRun, EXP_PULSE);
        chk(!memCeN && memDqOe && memBeN != 2'b11, "R4", "hold clock strobes",
            {memCeN, memDqOe, memBeN}, 0);
        chk(memAddr == prevAddr && memDqOut == prevData, "R4", "hold clock address/data",
            memAddr, prevAddr);
        lowRun  = 0;
        holdAge = 1;
      end else if (holdAge == 1) begin
        chk(!memDqOe && memCeN && memBeN == 2'b11, "R5", "release after hold",
            {memDqOe, memCeN, memBeN}, 4'b0111);
        holdAge = 0;
      end
      prevWeN  = memWeN;
      prevAddr = memAddr;
      prevData = memDqOut;
    end
  end

  // Driver: issue one request, push expectations, check the setup clock.
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [LN-1:0] m, input bit poke);
    int c;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqMask = m;
    c = cyc;
    if (m != 0) begin
      wrItem_t it;
      logic [DW-1:0] w;
      it.a = a; it.d = d; it.m = m;
      wrQ.push_back(it);
      w = expMem.exists(int'(a)) ? expMem[int'(a)] : 16'h0000;
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      expMem[int'(a)] = w;
      doneQ.push_back(c + 1 + EXP_TOTAL);
    end else begin
      doneQ.push_back(c + 1);
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (m != 0) begin
      chk(!memCeN && memWeN && memDqOe, "R2", "setup clock strobes",
          {memCeN, memWeN, memDqOe}, 3'b011);
      chk(memBeN == ~m, "R2", "setup lane enables", memBeN, ~m);
      chk(memAddr == a && memDqOut == d, "R2", "setup address/data", memAddr, a);
      @(negedge clk);
      chk(!memWeN, "R2", "strobe after one setup clock", memWeN, 0);
      if (poke) begin
        reqValid = 1'b1; reqAddr = 17'h0BEEF; reqData = 16'hDEAD; reqMask = 2'b11;
        @(negedge clk);
        reqValid = 1'b0;
        while (cyc < c + 1 + EXP_PULSE + 2) @(negedge clk);
        reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
      end
    end else begin
      chk(memCeN && memWeN && !memDqOe && memBeN == 2'b11, "R8", "zero mask keeps pins",
          {memCeN, memWeN, memDqOe, memBeN}, 5'b11011);
    end
    while (doneQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(memCeN && memWeN && memBeN == 2'b11 && !memDqOe && !reqDone, "R1", "pins in reset",
        {memCeN, memWeN, memBeN, memDqOe, reqDone}, 6'b111100);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCeN && memWeN && memBeN == 2'b11 && !memDqOe && !reqDone, "R1", "pins after reset",
        {memCeN, memWeN, memBeN, memDqOe, reqDone}, 6'b111100);

    doWrite(17'h00001, 16'hA5C3, 2'b11, 1'b0);
    doWrite(17'h1FFFF, 16'hFFFF, 2'b11, 1'b0);
    doWrite(17'h1FFFF, 16'h1234, 2'b01, 1'b0);   // R10 lower lane only
    doWrite(17'h1FFFF, 16'hABCD, 2'b10, 1'b0);   // R10 upper lane only
    doWrite(17'h00005, 16'h5555, 2'b00, 1'b0);   // R8
    doWrite(17'h00006, 16'h0F0F, 2'b01, 1'b0);
    doWrite(17'h00007, 16'h7777, 2'b11, 1'b1);   // R9 pokes during strobe and recovery
    doWrite(17'h00000, 16'h0000, 2'b00, 1'b0);   // R8
    doWrite(17'h00000, 16'h8001, 2'b10, 1'b0);

    // R8 / R9: nothing stored at the masked-off or poked addresses.
    chk(!modMem.exists(5), "R8", "zero mask wrote memory", 1, 0);
    chk(!modMem.exists(int'(17'h0BEEF)), "R9", "busy request wrote memory", 1, 0);
    // R10: merged contents of the partially written word.
    chk(modMem.exists(int'(17'h1FFFF)) && modMem[int'(17'h1FFFF)] == 16'hAB34, "R10",
        "merged lanes", modMem.exists(int'(17'h1FFFF)) ? modMem[int'(17'h1FFFF)] : 0, 16'hAB34);
    foreach (expMem[k]) begin
      chk(modMem.exists(k) && modMem[k] == expMem[k], "R10", "stored word",
          modMem.exists(k) ? modMem[k] : 0, expMem[k]);
    end
    chk(wrQ.size() == 0 && doneQ.size() == 0, "R6", "outstanding items",
        wrQ.size() + doneQ.size(), 0);
    summary();
    $finish;
  end

endmodule